// File: doc/BRIEF.md
# Flash Command Sequencer with Register Interface

This block is a small memory-mapped controller through which a CPU issues flash operations. It holds a behavioural byte array that stands in for the user area, plus two extra-area information bytes. Software loads a range start, a range end and a data byte, then selects an area. It writes an opcode to one of two command registers, either the main one or the extra-area one. The sequencer then programs one byte, erases a range, checks a range for blank state, or stores an extra-area information byte.

Each command uses a two-phase handshake. The opcode write starts the work, and a ready flag rises when the work is done. Software then writes 00h to the same command register, and ready falls. The error flags stay set until the sequencer-reset bit is written. Commands issued to the wrong area, unknown opcodes and reversed ranges are flagged as illegal and do nothing.

The controller is a single state machine with these states:
- ST_IDLE: accepts commands. It moves to ST_PROG, ST_ERASE, ST_BLANK or ST_XPROG for a valid opcode, and straight to ST_DONE for an illegal one.
- ST_PROG and ST_XPROG: count a fixed number of cycles, then move to ST_DONE.
- ST_ERASE and ST_BLANK: walk the range one byte per cycle. They move to ST_DONE at the range end, at the first byte that lies past the array, or, for ST_BLANK, at the first non-FFh byte.
- ST_DONE: raises the ready flag of the register that started the command. It returns to ST_IDLE when 00h is written to that register.
- ST_HOLD: entered from any state while the reset bit is 1. It returns to ST_IDLE once the bit is 0.

Register offsets:

| Offset | Contents |
|---|---|
| 0h | range start |
| 1h | range end |
| 2h | data byte |
| 3h | area select, bit 0 (1 = extra area) |
| 4h | main command |
| 5h | extra command |
| 6h | error flags (read) |
| 7h | ready flags (read) |
| 8h | sequencer reset, bit 0 |
| 9h | extra info slot 0 (read) |
| Ah | extra info slot 1 (read) |

Unused offsets read as zero.

Top module: `flash_cmd_seq`

## Requirements
- R1: After rst_n, all registers, error flags (offset 6h) and ready flags (offset 7h) read 0, and every array byte is FFh.
- R2: Main opcode 81h with area select 0 writes the data byte to the array at the range start. The main ready flag (bit 0 of offset 7h) rises exactly PROG_CYCLES cycles after the clock edge that took the opcode.
- R3: A program whose target byte is not FFh, or lies beyond the array, sets the program-fail flag (bit 1 of offset 6h) and leaves the array unchanged.
- R4: Main opcode 84h sets every byte from range start to range end to FFh. A byte beyond the array sets the erase-fail flag (bit 2) and ends the walk.
- R5: Main opcode 83h sets the blank-fail flag (bit 3) if any byte in the range is not FFh or lies beyond the array.
- R6: A ready flag stays 1 until 00h is written to the command register that started the command. 00h written to the other command register has no effect. Once the 00h write is taken, ready reads 0.
- R7: A main opcode that is unknown, or is issued with area select 1, or is an erase or blank check with start above end, sets the illegal flag (bit 0). No array access takes place, and the main ready flag still rises.
- R8: Extra opcode 81h (slot 0) or 82h (slot 1), issued with area select 1, stores the data byte in that info slot. It raises the extra ready flag (bit 1 of offset 7h).
- R9: An extra opcode other than 81h or 82h, or any extra opcode issued with area select 0, sets the extra-illegal flag (bit 4 of offset 6h) and stores nothing.
- R10: Error flags are sticky: a later successful command does not clear them.
- R11: Writing 1 to the reset bit aborts any command, clears all error and ready flags, and holds the sequencer. Writing 0 releases it to idle.
- R12: Writes to range start, range end, data and area select are ignored unless the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |

## Verification
The hardest case to reach is a sequencer reset that lands in the middle of a multi-cycle range walk while a sticky error is already pending. Both the abort and the clearing of the flags have to be seen at the ports. The bench first raises the illegal flag with a bad opcode and then starts a full-array erase. It writes the reset bit a few cycles into the walk, then confirms that both ready flags and all error flags read zero and that a fresh command completes. A second hard case is a register write that arrives while a command is still busy. The bench issues that write in the cycle straight after the opcode and reads the register back afterwards.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_BLANK,
        ST_XPROG,
        ST_DONE,
        ST_HOLD
    } seq_state_t;

    // register offsets
    localparam logic [3:0] RA_START  = 4'h0;
    localparam logic [3:0] RA_END    = 4'h1;
    localparam logic [3:0] RA_WDATA  = 4'h2;
    localparam logic [3:0] RA_AREA   = 4'h3;
    localparam logic [3:0] RA_CMD    = 4'h4;
    localparam logic [3:0] RA_XCMD   = 4'h5;
    localparam logic [3:0] RA_ERR    = 4'h6;
    localparam logic [3:0] RA_RDY    = 4'h7;
    localparam logic [3:0] RA_SRST   = 4'h8;
    localparam logic [3:0] RA_XINFO0 = 4'h9;
    localparam logic [3:0] RA_XINFO1 = 4'hA;

    // opcodes
    localparam logic [7:0] OP_NONE   = 8'h00;
    localparam logic [7:0] OP_PROG   = 8'h81;
    localparam logic [7:0] OP_BLANK  = 8'h83;
    localparam logic [7:0] OP_ERASE  = 8'h84;
    localparam logic [7:0] OP_XSLOT0 = 8'h81;
    localparam logic [7:0] OP_XSLOT1 = 8'h82;

    localparam logic [7:0] ERASED = 8'hFF;

    // error flag bit positions
    localparam int EB_ILL   = 0;
    localparam int EB_PFAIL = 1;
    localparam int EB_EFAIL = 2;
    localparam int EB_BFAIL = 3;
    localparam int EB_XILL  = 4;
    localparam int ERR_W    = 5;

endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              idle,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic [7:0]        data_q,
    output logic              area_q,
    output logic              srst_q
);

    logic cfg_open;
    assign cfg_open = bus_we && idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            data_q  <= '0;
            area_q  <= 1'b0;
            srst_q  <= 1'b0;
        end else begin
            if (cfg_open && bus_addr == RA_START) start_q <= bus_wdata[ADDR_W-1:0];
            if (cfg_open && bus_addr == RA_END)   end_q   <= bus_wdata[ADDR_W-1:0];
            if (cfg_open && bus_addr == RA_WDATA) data_q  <= bus_wdata;
            if (cfg_open && bus_addr == RA_AREA)  area_q  <= bus_wdata[0];
            if (bus_we && bus_addr == RA_SRST)    srst_q  <= bus_wdata[0];
        end
    end

endmodule

// File: rtl/fseq_array.sv
module fseq_array
    import fseq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DEPTH       = 64,
    parameter int PROG_CYCLES = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              area,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] end_q,
    input  logic [7:0]        data_q,
    input  logic [7:0]        mem_rdata,
    output logic              idle,
    output logic              rdy,
    output logic              xrdy,
    output logic [ERR_W-1:0]  err,
    output logic [7:0]        xinfo0,
    output logic [7:0]        xinfo1,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  CLAST = CNT_W'(PROG_CYCLES - 1);

    seq_state_t         state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  ptr;
    logic               xside;
    logic               xsel;
    logic [ERR_W-1:0]   err_q;

    logic cmd_wr, xcmd_wr, main_ok, x_ok, cnt_last, ptr_out, start_out;
    logic prog_ok, release_ack;

    assign cmd_wr    = bus_we && bus_addr == RA_CMD  && bus_wdata != OP_NONE;
    assign xcmd_wr   = bus_we && bus_addr == RA_XCMD && bus_wdata != OP_NONE;
    assign main_ok   = !area && (bus_wdata == OP_PROG ||
                       ((bus_wdata == OP_ERASE || bus_wdata == OP_BLANK) && start_q <= end_q));
    assign x_ok      = area && (bus_wdata == OP_XSLOT0 || bus_wdata == OP_XSLOT1);
    assign cnt_last  = cnt == CLAST;
    assign ptr_out   = ptr > LAST;
    assign start_out = start_q > LAST;
    assign prog_ok   = !start_out && mem_rdata == ERASED;
    assign release_ack = bus_we && bus_wdata == OP_NONE &&
                         bus_addr == (xside ? RA_XCMD : RA_CMD);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    if (!main_ok)                   nxt = ST_DONE;
                    else if (bus_wdata == OP_PROG)  nxt = ST_PROG;
                    else if (bus_wdata == OP_ERASE) nxt = ST_ERASE;
                    else                            nxt = ST_BLANK;
                end else if (xcmd_wr) begin
                    nxt = x_ok ? ST_XPROG : ST_DONE;
                end
            end
            ST_PROG, ST_XPROG: if (cnt_last) nxt = ST_DONE;
            ST_ERASE: if (ptr_out || ptr == end_q) nxt = ST_DONE;
            ST_BLANK: if (ptr_out || mem_rdata != ERASED || ptr == end_q) nxt = ST_DONE;
            ST_DONE:  if (release_ack) nxt = ST_IDLE;
            ST_HOLD:  if (!srst) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (srst) nxt = ST_HOLD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            ptr    <= '0;
            xside  <= 1'b0;
            xsel   <= 1'b0;
            err_q  <= '0;
            xinfo0 <= '0;
            xinfo1 <= '0;
        end else if (srst) begin
            cnt   <= '0;
            xside <= 1'b0;
            err_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    ptr <= start_q;
                    if (cmd_wr) begin
                        xside <= 1'b0;
                        if (!main_ok) err_q[EB_ILL] <= 1'b1;
                    end else if (xcmd_wr) begin
                        xside <= 1'b1;
                        xsel  <= bus_wdata == OP_XSLOT1;
                        if (!x_ok) err_q[EB_XILL] <= 1'b1;
                    end
                end
                ST_PROG: begin
                    cnt <= cnt + 1'b1;
                    if (cnt_last && !prog_ok) err_q[EB_PFAIL] <= 1'b1;
                end
                ST_XPROG: begin
                    cnt <= cnt + 1'b1;
                    if (cnt_last) begin
                        if (xsel) xinfo1 <= data_q;
                        else      xinfo0 <= data_q;
                    end
                end
                ST_ERASE: begin
                    ptr <= ptr + 1'b1;
                    if (ptr_out) err_q[EB_EFAIL] <= 1'b1;
                end
                ST_BLANK: begin
                    ptr <= ptr + 1'b1;
                    if (ptr_out || mem_rdata != ERASED) err_q[EB_BFAIL] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        idle      = state == ST_IDLE;
        rdy       = state == ST_DONE && !xside;
        xrdy      = state == ST_DONE && xside;
        err       = err_q;
        mem_addr  = (state == ST_PROG) ? start_q[IDX_W-1:0] : ptr[IDX_W-1:0];
        mem_wdata = (state == ST_PROG) ? data_q : ERASED;
        mem_we    = !srst && ((state == ST_PROG && cnt_last && prog_ok) ||
                              (state == ST_ERASE && !ptr_out));
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DEPTH       = 64,
    parameter int PROG_CYCLES = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    logic [ADDR_W-1:0] start_q, end_q;
    logic [7:0]        data_q, xinfo0, xinfo1, mem_rdata, mem_wdata;
    logic              area_q, srst_q, idle, busy, rdy, xrdy, mem_we;
    logic [ERR_W-1:0]  err;
    logic [IDX_W-1:0]  mem_addr;

    assign busy = !idle;

    fseq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .idle(idle), .start_q(start_q), .end_q(end_q),
        .data_q(data_q), .area_q(area_q), .srst_q(srst_q)
    );

    fseq_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    fseq_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .srst(srst_q), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .area(area_q),
        .start_q(start_q), .end_q(end_q), .data_q(data_q), .mem_rdata(mem_rdata),
        .idle(idle), .rdy(rdy), .xrdy(xrdy), .err(err), .xinfo0(xinfo0),
        .xinfo1(xinfo1), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always_comb begin
        case (bus_addr)
            RA_START:  bus_rdata = 8'(start_q);
            RA_END:    bus_rdata = 8'(end_q);
            RA_WDATA:  bus_rdata = data_q;
            RA_AREA:   bus_rdata = {7'b0, area_q};
            RA_ERR:    bus_rdata = {3'b0, err};
            RA_RDY:    bus_rdata = {6'b0, xrdy, rdy};
            RA_SRST:   bus_rdata = {7'b0, srst_q};
            RA_XINFO0: bus_rdata = xinfo0;
            RA_XINFO1: bus_rdata = xinfo1;
            default:   bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [3:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              rdy,
    input logic              xrdy,
    input logic              busy,
    input logic              srst,
    input logic [ERR_W-1:0]  err,
    input logic [ADDR_W-1:0] start_q
);

    logic main_ack;
    assign main_ack = bus_we && bus_addr == RA_CMD && bus_wdata == OP_NONE;

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && !srst && !main_ack |=> rdy); // R6

    AST_ACK_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && !srst && main_ack |=> !rdy && !busy); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> err == '0 && !rdy && !xrdy); // R11

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !srst |=> (err & $past(err)) == $past(err)); // R10

    AST_START_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(start_q)); // R12

endmodule

bind flash_cmd_seq fseq_checker #(.ADDR_W(ADDR_W)) u_fseq_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rdy(rdy), .xrdy(xrdy), .busy(busy),
    .srst(srst_q), .err(err), .start_q(start_q)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
    import fseq_pkg::*;

    localparam int PROG_CYCLES = 8;
    localparam int NVEC = 19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(8), .DEPTH(64), .PROG_CYCLES(PROG_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // {opcode, extra register, area, start, end, data, expected error flags}
    localparam logic [41:0] VECS [NVEC] = '{
        {8'h83, 1'b0, 1'b0, 8'd0,   8'd63, 8'h00, 8'h00}, // R1 R5 clean array
        {8'h81, 1'b0, 1'b0, 8'd5,   8'd0,  8'hA5, 8'h00}, // R2 program
        {8'h81, 1'b0, 1'b0, 8'd5,   8'd0,  8'h11, 8'h02}, // R3 reprogram fails
        {8'h83, 1'b0, 1'b0, 8'd0,   8'd4,  8'h00, 8'h00}, // R5
        {8'h83, 1'b0, 1'b0, 8'd4,   8'd6,  8'h00, 8'h08}, // R5 finds written byte
        {8'h84, 1'b0, 1'b0, 8'd4,   8'd6,  8'h00, 8'h00}, // R4 erase
        {8'h83, 1'b0, 1'b0, 8'd4,   8'd6,  8'h00, 8'h00}, // R4 erased range blank
        {8'h84, 1'b0, 1'b0, 8'd9,   8'd3,  8'h00, 8'h01}, // R7 reversed range
        {8'h81, 1'b0, 1'b1, 8'd7,   8'd0,  8'h00, 8'h01}, // R7 wrong area
        {8'h55, 1'b0, 1'b0, 8'd7,   8'd0,  8'h00, 8'h01}, // R7 unknown opcode
        {8'h81, 1'b1, 1'b1, 8'd0,   8'd0,  8'h3C, 8'h00}, // R8 slot 0
        {8'h82, 1'b1, 1'b0, 8'd0,   8'd0,  8'h99, 8'h10}, // R9 wrong area
        {8'h84, 1'b1, 1'b1, 8'd0,   8'd0,  8'h99, 8'h10}, // R9 unknown
        {8'h84, 1'b0, 1'b0, 8'd60,  8'd70, 8'h00, 8'h04}, // R4 past array
        {8'h83, 1'b0, 1'b0, 8'd60,  8'd63, 8'h00, 8'h00}, // R4 tail erased
        {8'h81, 1'b0, 1'b0, 8'd200, 8'd0,  8'h12, 8'h02}, // R3 out of range
        {8'h83, 1'b0, 1'b0, 8'd70,  8'd80, 8'h00, 8'h08}, // R5 out of range
        {8'h82, 1'b1, 1'b1, 8'd0,   8'd0,  8'hC3, 8'h00}, // R8 slot 1
        {8'h83, 1'b0, 1'b0, 8'd7,   8'd7,  8'h00, 8'h00}  // R7 byte 7 untouched
    };

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_rdy(output logic [7:0] v);
        for (int i = 0; i < 3000; i++) begin
            rd(RA_RDY, v);
            if (v != 8'h00) break;
            @(negedge clk);
        end
    endtask

    task automatic seq_reset();
        wr(RA_SRST, 8'h01);
        wr(RA_SRST, 8'h00);
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [3:0] reg_a, input logic [7:0] op,
                           input logic [7:0] rexp, input string req);
        logic [7:0] v;
        wr(reg_a, op);
        wait_rdy(v);
        chk(req, v, rexp);
        wr(reg_a, 8'h00);
        rd(RA_RDY, v);
        chk(req, v, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(RA_ERR, v);   chk("R1 err", v, 8'h00);
        rd(RA_RDY, v);   chk("R1 rdy", v, 8'h00);
        rd(RA_START, v); chk("R1 start", v, 8'h00);
        rd(RA_AREA, v);  chk("R1 area", v, 8'h00);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [41:0] e;
            e = VECS[i];
            seq_reset();
            wr(RA_AREA, {7'b0, e[32]});
            wr(RA_START, e[31:24]);
            wr(RA_END, e[23:16]);
            wr(RA_WDATA, e[15:8]);
            run_cmd(e[33] ? RA_XCMD : RA_CMD, e[41:34], e[33] ? 8'h02 : 8'h01,
                    $sformatf("vector %0d ready", i));
            rd(RA_ERR, v);
            chk($sformatf("vector %0d flags", i), v, e[7:0]);
        end
        rd(RA_XINFO0, v); chk("R8 slot0", v, 8'h3C);
        rd(RA_XINFO1, v); chk("R8 slot1", v, 8'hC3);

        // R2 exact program latency
        seq_reset();
        wr(RA_AREA, 8'h00);
        wr(RA_START, 8'd20);
        wr(RA_WDATA, 8'h5A);
        wr(RA_CMD, OP_PROG);
        repeat (PROG_CYCLES - 1) @(posedge clk);
        @(negedge clk);
        rd(RA_RDY, v); chk("R2 not yet ready", v, 8'h00);
        @(posedge clk);
        @(negedge clk);
        rd(RA_RDY, v); chk("R2 ready on time", v, 8'h01);
        // R6 zero to the other register is ignored
        wr(RA_XCMD, 8'h00);
        rd(RA_RDY, v); chk("R6 other register ack ignored", v, 8'h01);
        // R12 area write while waiting for ack is ignored
        wr(RA_AREA, 8'h01);
        rd(RA_AREA, v); chk("R12 area frozen", v, 8'h00);
        wr(RA_CMD, 8'h00);
        rd(RA_RDY, v); chk("R6 ack drops ready", v, 8'h00);

        // R12 start write during a busy program is ignored
        wr(RA_START, 8'd21);
        wr(RA_CMD, OP_PROG);
        wr(RA_START, 8'd33);
        rd(RA_START, v); chk("R12 start frozen", v, 8'd21);
        wait_rdy(v);
        wr(RA_CMD, 8'h00);

        // R10 sticky flags: illegal then a clean command
        seq_reset();
        run_cmd(RA_CMD, 8'h77, 8'h01, "R7 unknown ready");
        wr(RA_START, 8'd0);
        wr(RA_END, 8'd3);
        run_cmd(RA_CMD, OP_BLANK, 8'h01, "R10 blank ready");
        rd(RA_ERR, v); chk("R10 flag kept", v, 8'h01);

        // R11 reset during a long erase with a pending flag
        wr(RA_START, 8'd0);
        wr(RA_END, 8'd63);
        wr(RA_CMD, OP_ERASE);
        repeat (3) @(negedge clk);
        wr(RA_SRST, 8'h01);
        @(negedge clk);
        rd(RA_RDY, v); chk("R11 ready cleared", v, 8'h00);
        rd(RA_ERR, v); chk("R11 flags cleared", v, 8'h00);
        wr(RA_SRST, 8'h00);
        @(negedge clk);
        wr(RA_START, 8'd62);
        wr(RA_END, 8'd63);
        run_cmd(RA_CMD, OP_BLANK, 8'h01, "R11 works after release");
        rd(RA_ERR, v); chk("R11 clean after release", v, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule